// File: doc/BRIEF.md
# Clock Multiplier Ready Timer

This block sequences the lock wait of an on-chip clock multiplier as software sees it. Software writes a power-control byte. When the written value selects multiplier mode, a lock wait begins and a ready flag in a separate event-flag byte goes low. After a programmed number of counted cycles the flag goes high again, and software polls it before it trusts the faster clock. Any other power-control value aborts a wait that is in progress. The block does not gate or switch a clock. It only keeps the two register bytes and the lock-wait state.

Both registers share one byte-wide write port and one byte-wide read port, each with a one-bit register select (0 = power-control, 1 = event-flag). A `cycle_tick` strobe marks the cycles that count toward the lock time. It can be tied high, or driven from a divided clock enable.

Top module: `clkmul_ready_timer`

## Requirements
- R1: A write to the power-control register stores the written byte with bits 1 and 0 forced to 1. Its reset value is 0x03.
- R2: A power-control write whose value ANDed with 0xD0 equals 0x90 (bit 7 = 1, bit 6 = 0, bit 4 = 1) starts the lock wait, and clears event-flag bit 3 from the following cycle.
- R3: A power-control write with any other value of bits 7, 6 and 4 cancels a running lock wait. Event-flag bit 3 keeps its value.
- R4: Event-flag bit 3 becomes 1 on the cycle in which the LOCK_TICKS-th tick after the starting write is counted (default 65535), and the wait then stops.
- R5: Only cycles with `cycle_tick` high count toward the lock time. Cycles with it low leave the wait paused.
- R6: A write to the event-flag register stores every bit except bit 3. Bit 3 ignores software writes.
- R7: A qualifying power-control write while a wait is running restarts the count from zero.
- R8: After reset the power-control register reads 0x03, the event-flag register reads 0x00, and no wait is running.
- R9: When a power-control write lands in the cycle that would complete the wait, the write wins. A cancel leaves bit 3 at 0, and a restart begins a full new wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_tick | input | 1 | Marks a cycle that counts toward the lock time |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 power-control, 1 event-flag |
| reg_wr_data | input | DATA_W | Write data |
| reg_rd_sel | input | 1 | Read source: 0 power-control, 1 event-flag |
| reg_rd_data | output | DATA_W | Read data of the selected register |

## Verification
The internal wait state can only be seen through event-flag bit 3. A counter that is off by one, runs on untick'd cycles, or fails to restart or cancel shows up only as bit 3 rising one or more cycles early or late, or not rising at all. That difference appears no sooner than LOCK_TICKS ticks after the start. For this reason the bench runs every wait to its end against a cycle-accurate model and compares the read port on every clock. It also covers the same-cycle collisions between a completing wait and a new write. Errors in the write masks are visible on the very next read of the affected register.

// File: rtl/clkmul_ready_timer_pkg.sv
package clkmul_ready_timer_pkg;

   typedef enum logic {
      SEL_PWR  = 1'b0,
      SEL_FLAG = 1'b1
   } reg_sel_e;

   typedef struct packed {
      logic start;
      logic cancel;
   } wait_ctl_t;

endpackage

// File: rtl/clkmul_pwr_reg.sv
module clkmul_pwr_reg
   import clkmul_ready_timer_pkg::*;
#(
   parameter int                DATA_W     = 8,
   parameter logic [DATA_W-1:0] FORCE_MASK = 'h03,
   parameter logic [DATA_W-1:0] MATCH_MASK = 'hD0,
   parameter logic [DATA_W-1:0] MATCH_VAL  = 'h90
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] q,
   output wait_ctl_t         ctl
);
   logic hit;

   assign hit        = (wr_data & MATCH_MASK) == MATCH_VAL;
   assign ctl.start  = wr_en && hit;
   assign ctl.cancel = wr_en && !hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= FORCE_MASK;
      else if (wr_en)
         q <= wr_data | FORCE_MASK;
   end
endmodule

// File: rtl/clkmul_lock_timer.sv
module clkmul_lock_timer
   import clkmul_ready_timer_pkg::*;
#(
   parameter int LOCK_TICKS = 65535,
   localparam int CNT_W = (LOCK_TICKS > 1) ? $clog2(LOCK_TICKS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wait_ctl_t        ctl,
   input  logic             tick,
   output logic             busy,
   output logic [CNT_W-1:0] cnt,
   output logic             done
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_TICKS - 1);

   logic at_end;

   generate
      if (LOCK_TICKS == 1) begin : g_single
         assign at_end = 1'b1;
      end else begin : g_count
         assign at_end = (cnt == LAST);
      end
   endgenerate

   assign done = busy && tick && at_end && !ctl.start && !ctl.cancel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (ctl.start) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (ctl.cancel) begin
         busy <= 1'b0;
      end else if (busy && tick) begin
         if (at_end)
            busy <= 1'b0;
         else
            cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/clkmul_flag_reg.sv
module clkmul_flag_reg #(
   parameter int DATA_W    = 8,
   parameter int READY_BIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr_ready,
   input  logic              set_ready,
   output logic [DATA_W-1:0] q
);
   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         if (b == READY_BIT) begin : g_status
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q[b] <= 1'b0;
               else if (clr_ready)
                  q[b] <= 1'b0;
               else if (set_ready)
                  q[b] <= 1'b1;
            end
         end else begin : g_store
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q[b] <= 1'b0;
               else if (wr_en)
                  q[b] <= wr_data[b];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/clkmul_ready_timer.sv
module clkmul_ready_timer
   import clkmul_ready_timer_pkg::*;
#(
   parameter int                DATA_W     = 8,
   parameter int                LOCK_TICKS = 65535,
   parameter int                READY_BIT  = 3,
   parameter logic [DATA_W-1:0] FORCE_MASK = 'h03,
   parameter logic [DATA_W-1:0] MATCH_MASK = 'hD0,
   parameter logic [DATA_W-1:0] MATCH_VAL  = 'h90
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cycle_tick,
   input  logic              reg_wr_en,
   input  logic              reg_wr_sel,
   input  logic [DATA_W-1:0] reg_wr_data,
   input  logic              reg_rd_sel,
   output logic [DATA_W-1:0] reg_rd_data
);
   localparam int CNT_W = (LOCK_TICKS > 1) ? $clog2(LOCK_TICKS) : 1;

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("DATA_W must be at least 4");
      end
      if (LOCK_TICKS < 1) begin : g_bad_lock
         $error("LOCK_TICKS must be at least 1");
      end
      if (READY_BIT < 0 || READY_BIT >= DATA_W) begin : g_bad_bit
         $error("READY_BIT out of range");
      end
      if ((MATCH_VAL & ~MATCH_MASK) != '0) begin : g_bad_match
         $error("MATCH_VAL has bits outside MATCH_MASK");
      end
   endgenerate

   reg_sel_e          wr_sel, rd_sel;
   logic              pwr_wr, flag_wr;
   logic [DATA_W-1:0] pwr_q, flag_q;
   wait_ctl_t         ctl;
   logic              lock_busy, lock_done;
   logic [CNT_W-1:0]  lock_cnt;

   assign wr_sel  = reg_sel_e'(reg_wr_sel);
   assign rd_sel  = reg_sel_e'(reg_rd_sel);
   assign pwr_wr  = reg_wr_en && (wr_sel == SEL_PWR);
   assign flag_wr = reg_wr_en && (wr_sel == SEL_FLAG);

   clkmul_pwr_reg #(
      .DATA_W(DATA_W), .FORCE_MASK(FORCE_MASK),
      .MATCH_MASK(MATCH_MASK), .MATCH_VAL(MATCH_VAL)
   ) pwr_i (
      .clk(clk), .rst_n(rst_n), .wr_en(pwr_wr), .wr_data(reg_wr_data),
      .q(pwr_q), .ctl(ctl)
   );

   clkmul_lock_timer #(.LOCK_TICKS(LOCK_TICKS)) timer_i (
      .clk(clk), .rst_n(rst_n), .ctl(ctl), .tick(cycle_tick),
      .busy(lock_busy), .cnt(lock_cnt), .done(lock_done)
   );

   clkmul_flag_reg #(.DATA_W(DATA_W), .READY_BIT(READY_BIT)) flag_i (
      .clk(clk), .rst_n(rst_n), .wr_en(flag_wr), .wr_data(reg_wr_data),
      .clr_ready(ctl.start), .set_ready(lock_done), .q(flag_q)
   );

   always_comb begin
      unique case (rd_sel)
         SEL_FLAG: reg_rd_data = flag_q;
         default:  reg_rd_data = pwr_q;
      endcase
   end
endmodule

// File: rtl/clkmul_ready_timer_chk.sv
module clkmul_ready_timer_chk #(
   parameter int                DATA_W     = 8,
   parameter int                LOCK_TICKS = 65535,
   parameter int                READY_BIT  = 3,
   parameter int                CNT_W      = 16,
   parameter logic [DATA_W-1:0] FORCE_MASK = 'h03,
   parameter logic [DATA_W-1:0] MATCH_MASK = 'hD0,
   parameter logic [DATA_W-1:0] MATCH_VAL  = 'h90
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cycle_tick,
   input logic              reg_wr_en,
   input logic              reg_wr_sel,
   input logic [DATA_W-1:0] reg_wr_data,
   input logic [DATA_W-1:0] pwr_q,
   input logic [DATA_W-1:0] flag_q,
   input logic              busy,
   input logic [CNT_W-1:0]  cnt
);
   logic pw, fw, qual;
   assign pw   = reg_wr_en && !reg_wr_sel;
   assign fw   = reg_wr_en && reg_wr_sel;
   assign qual = (reg_wr_data & MATCH_MASK) == MATCH_VAL;

   assert_low_bits_forced_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pw |=> ((pwr_q & FORCE_MASK) == FORCE_MASK));

   assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pw && qual) |=> (busy && !flag_q[READY_BIT] && cnt == '0));

   assert_cancel_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pw && !qual) |=> (!busy && $stable(flag_q[READY_BIT])));

   assert_ready_after_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[READY_BIT]) |-> ($past(busy) && $past(cycle_tick) && !busy));

   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (int'(cnt) < LOCK_TICKS));

   assert_pause_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cycle_tick && !pw) |=> (busy && $stable(cnt)));

   assert_ready_ignores_sw_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fw && !busy) |=> $stable(flag_q[READY_BIT]));
endmodule

bind clkmul_ready_timer clkmul_ready_timer_chk #(
   .DATA_W(DATA_W), .LOCK_TICKS(LOCK_TICKS), .READY_BIT(READY_BIT),
   .CNT_W(CNT_W), .FORCE_MASK(FORCE_MASK),
   .MATCH_MASK(MATCH_MASK), .MATCH_VAL(MATCH_VAL)
) chk_i (
   .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick),
   .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
   .pwr_q(pwr_q), .flag_q(flag_q), .busy(lock_busy), .cnt(lock_cnt)
);

// File: tb/clkmul_ready_timer_tb_top.sv
`timescale 1ns/1ps
module clkmul_ready_timer_tb_top;
   localparam int LOCK = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cycle_tick = 1'b0;
   logic       reg_wr_en = 1'b0;
   logic       reg_wr_sel = 1'b0;
   logic [7:0] reg_wr_data = 8'h00;
   logic       reg_rd_sel = 1'b0;
   logic [7:0] reg_rd_data;

   int n_run = 0, n_fail = 0, cyc = 0;
   bit done = 0;

   always #2 clk = ~clk;

   clkmul_ready_timer #(.LOCK_TICKS(LOCK)) dut_i (
      .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick),
      .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
      .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data)
   );

   // behavioural reference model
   int m_pwr = 3, m_flag = 0, m_cnt = 0;
   bit m_run = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_pwr = 3; m_flag = 0; m_cnt = 0; m_run = 0;
      end else begin
         bit wrote_pwr;
         wrote_pwr = reg_wr_en && !reg_wr_sel;
         if (wrote_pwr) begin
            m_pwr = int'(reg_wr_data) | 3;
            if ((int'(reg_wr_data) & 'hD0) == 'h90) begin
               m_run = 1; m_cnt = 0; m_flag = m_flag & ~8;
            end else
               m_run = 0;
         end else if (reg_wr_en)
            m_flag = (int'(reg_wr_data) & ~8) | (m_flag & 8);
         if (!wrote_pwr && m_run && cycle_tick) begin
            m_cnt++;
            if (m_cnt == LOCK) begin
               m_flag = m_flag | 8;
               m_run = 0;
            end
         end
      end
   end

   always @(posedge clk) begin
      #1;
      if (!done) begin
         int exp;
         exp = reg_rd_sel ? m_flag : m_pwr;
         n_run++;
         if (int'(reg_rd_data) != exp) begin
            n_fail++;
            $display("FAIL model R1 R2 R3 R4 R5 R6 R7 R8 R9 sel=%0d actual=%h expected=%h",
                     reg_rd_sel, reg_rd_data, exp[7:0]);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 200000 && !done) begin
         done = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=<200000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic step(input bit we, input bit sel, input logic [7:0] d, input bit tk);
      @(negedge clk);
      reg_wr_en = we; reg_wr_sel = sel; reg_wr_data = d; cycle_tick = tk;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 8'h00, 1);
   endtask

   task automatic peek(input string tag, input bit sel, input logic [7:0] mask,
                       input logic [7:0] exp);
      step(0, 0, 8'h00, 0);
      reg_rd_sel = sel;
      #1;
      n_run++;
      if ((reg_rd_data & mask) !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, reg_rd_data & mask, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      peek("R8 reset pwr", 0, 8'hFF, 8'h03);
      peek("R8 reset flag", 1, 8'hFF, 8'h00);
      rst_n = 1'b1;
      peek("R8 idle pwr", 0, 8'hFF, 8'h03);

      step(1, 0, 8'h00, 0); peek("R1 force 00", 0, 8'hFF, 8'h03);
      step(1, 0, 8'hFC, 0); peek("R1 force FC", 0, 8'hFF, 8'hFF);
      step(1, 1, 8'hFF, 0); peek("R6 bit3 write ignored", 1, 8'hFF, 8'hF7);
      step(1, 1, 8'h5A, 0); peek("R6 storage bits", 1, 8'hFF, 8'h52);

      // first wait to completion
      step(1, 0, 8'h90, 0);
      ticks(LOCK - 1); peek("R4 not yet", 1, 8'h08, 8'h00);
      peek("R5 paused no tick", 1, 8'h08, 8'h00);
      ticks(1); peek("R4 ready at lock", 1, 8'h08, 8'h08);
      step(1, 1, 8'h00, 0); peek("R6 ready kept on write 0", 1, 8'hFF, 8'h08);

      // start with other pattern clears ready
      step(1, 0, 8'hB3, 0); peek("R2 start clears", 1, 8'h08, 8'h00);
      peek("R2 pwr stored", 0, 8'hFF, 8'hB3);
      repeat (100) step(0, 0, 8'h00, 0);
      peek("R5 untick cycles", 1, 8'h08, 8'h00);
      ticks(LOCK); peek("R4 second lock", 1, 8'h08, 8'h08);

      // cancel
      step(1, 0, 8'h90, 0); ticks(20);
      step(1, 0, 8'h10, 0); ticks(LOCK + 10);
      peek("R3 cancelled", 1, 8'h08, 8'h00);
      step(1, 0, 8'hD0, 0); peek("R3 pattern D0 no start", 1, 8'h08, 8'h00);
      ticks(LOCK + 5); peek("R3 still idle", 1, 8'h08, 8'h00);

      // restart
      step(1, 0, 8'h90, 0); ticks(30);
      step(1, 0, 8'h94, 0); ticks(LOCK - 1);
      peek("R7 restart not early", 1, 8'h08, 8'h00);
      ticks(1); peek("R7 restart full wait", 1, 8'h08, 8'h08);

      // collisions on the completing cycle
      step(1, 0, 8'h90, 0); ticks(LOCK - 1);
      step(1, 0, 8'h00, 1); ticks(3);
      peek("R9 cancel beats done", 1, 8'h08, 8'h00);
      step(1, 0, 8'h90, 0); ticks(LOCK - 1);
      step(1, 0, 8'h90, 1); ticks(LOCK - 1);
      peek("R9 restart beats done", 1, 8'h08, 8'h00);
      ticks(1); peek("R9 restart completes", 1, 8'h08, 8'h08);

      // reset mid-wait
      step(1, 0, 8'h90, 0); ticks(10);
      @(negedge clk); rst_n = 1'b0;
      peek("R8 mid reset flag", 1, 8'hFF, 8'h00);
      rst_n = 1'b1;
      ticks(LOCK + 5);
      peek("R8 no wait after reset", 1, 8'h08, 8'h00);
      peek("R8 pwr after reset", 0, 8'hFF, 8'h03);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule